// File: doc/BRIEF.md
# Integer Add/Logic Micro-Op Execution Unit

This unit executes one 64-bit integer micro-op per clock. Each op supplies up to three source operand values and the carry flag that belongs to the second source. It also carries a signed immediate packed into a low field and a sign bit, the program counter, and a set of control bits. There are two op kinds.

The add kind forms a sum of an optionally inverted first source, the second source or its carry flag, an optional third source, the immediate, and an optional program counter. Subtraction and borrow chains are built from operand inversion and carry-in control, not from a separate opcode. The logic kind applies a 4-bit truth table to the first two sources, bit by bit.

A final width stage narrows, extends or duplicates the result. The result and a carry-out flag come out registered, one cycle after the op is accepted.

Top module: `int_mop_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `out_result` and `out_carry` are 0. `in_ready` is 1 whenever `rst` is 0.
- R2: An op accepted at a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` 1 for exactly the following cycle. `out_valid` is 0 after any edge with no accepted op.
- R3: For the add kind (`in_kind`=0) with `in_three_src`=1, the sum is A + B + `in_src2` + imm + P + cin, modulo 2^64. A is `in_src0`, or its complement when `in_inv_src0`=1. The immediate imm is the 26-bit value {`in_imm_sign`, `in_imm_low`[24:0]}, sign-extended.
- R4: For the add kind with `in_three_src`=0, `in_src2` is not an addend. Instead its low 8 bits form the middle of a 34-bit immediate {`in_imm_sign`, `in_src2`[7:0], `in_imm_low`[24:0]}, which is sign-extended.
- R5: When `in_carry_sel`=1, B is 0 and the raw carry-in is `in_src1_cf`. When `in_carry_sel`=0, B is `in_src1` and the raw carry-in is 0.
- R6: cin is the raw carry-in, complemented when `in_inv_cin`=1.
- R7: `out_carry` is bit 64 of A + (B + C + imm + P mod 2^64) + cin, where C is the third-source addend. It is taken before the width stage. For the logic kind it is 0.
- R8: For the logic kind (`in_kind`=1), result bit i is `in_lut`[{`in_src0`[i], `in_src1`[i]}]. `in_src2`, the immediate, the program counter and the add controls have no effect.
- R9: `in_mode` selects the width stage: 0 full, 1 low 32 bits in both halves, 2 zero-extend 32, 3 sign-extend 32, 4 zero-extend 16, 5 sign-extend 16, 6 zero-extend 8, 7 sign-extend 8.
- R10: P is `in_pc` when `in_add_pc`=1, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Op offered |
| in_ready | output | 1 | Unit can accept an op |
| in_kind | input | 1 | 0 add, 1 logic |
| in_src0 | input | 64 | First source value |
| in_src1 | input | 64 | Second source value |
| in_src1_cf | input | 1 | Carry flag of the second source |
| in_src2 | input | 64 | Third source value or immediate chunk |
| in_three_src | input | 1 | Add uses three sources (26-bit immediate) |
| in_imm_low | input | 25 | Low immediate field |
| in_imm_sign | input | 1 | Immediate sign bit |
| in_pc | input | 64 | Program counter of the op |
| in_inv_src0 | input | 1 | Complement first source |
| in_carry_sel | input | 1 | Second source gives only its carry flag |
| in_inv_cin | input | 1 | Complement carry-in |
| in_add_pc | input | 1 | Add the program counter |
| in_lut | input | 4 | Logic truth table |
| in_mode | input | 3 | Output width mode |
| out_valid | output | 1 | Result valid this cycle |
| out_result | output | 64 | Registered result |
| out_carry | output | 1 | Registered carry-out |

## Verification
The properties assume that `in_mode` and `in_kind` are held for the whole cycle in which an op is accepted. The width-stage checks also assume the default 64-bit data width, so that the 8-, 16- and 32-bit boundaries fall at bit 8, 16 and 32. The bench drives all inputs only just after the falling edge and keeps them stable through the next rising edge. It uses only the eight mode encodings and fully defined operand values, so no X reaches the sum or the width stage.

// File: rtl/int_mop_pkg.sv
package int_mop_pkg;
  typedef enum logic [2:0] {
    WM_FULL  = 3'd0,
    WM_DUP32 = 3'd1,
    WM_ZX32  = 3'd2,
    WM_SX32  = 3'd3,
    WM_ZX16  = 3'd4,
    WM_SX16  = 3'd5,
    WM_ZX8   = 3'd6,
    WM_SX8   = 3'd7
  } width_mode_e;
endpackage

// File: rtl/int_mop_adder.sv
module int_mop_adder #(
  parameter int DATA_W    = 64,
  parameter int IMM_LOW_W = 25,
  parameter int CHUNK_W   = 8
) (
  input  logic [DATA_W-1:0]    src0,
  input  logic [DATA_W-1:0]    src1,
  input  logic                 src1_cf,
  input  logic [DATA_W-1:0]    src2,
  input  logic                 three_src,
  input  logic [IMM_LOW_W-1:0] imm_low,
  input  logic                 imm_sign,
  input  logic [DATA_W-1:0]    pc,
  input  logic                 inv_src0,
  input  logic                 carry_sel,
  input  logic                 inv_cin,
  input  logic                 add_pc,
  output logic [DATA_W-1:0]    sum,
  output logic                 carry
);
  localparam int SX3_W = DATA_W - IMM_LOW_W;
  localparam int SX2_W = DATA_W - IMM_LOW_W - CHUNK_W;

  logic [DATA_W-1:0] opa, opb, opc, oppc, imm_ext, partial;
  logic              cin;
  logic [DATA_W:0]   core;

  always_comb begin
    opa  = inv_src0 ? ~src0 : src0;
    opb  = carry_sel ? '0 : src1;
    cin  = (carry_sel & src1_cf) ^ inv_cin;
    oppc = add_pc ? pc : '0;
    if (three_src) begin
      opc     = src2;
      imm_ext = {{SX3_W{imm_sign}}, imm_low};
    end else begin
      opc     = '0;
      imm_ext = {{SX2_W{imm_sign}}, src2[CHUNK_W-1:0], imm_low};
    end
    partial = opb + opc + imm_ext + oppc;
    core    = {1'b0, opa} + {1'b0, partial} + {{DATA_W{1'b0}}, cin};
    sum     = core[DATA_W-1:0];
    carry   = core[DATA_W];
  end
endmodule

// File: rtl/int_mop_lut_logic.sv
module int_mop_lut_logic #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        lut,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y[i] = lut[{a[i], b[i]}];
  end
endmodule

// File: rtl/int_mop_width_stage.sv
module int_mop_width_stage
  import int_mop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] d,
  input  width_mode_e       mode,
  output logic [DATA_W-1:0] y
);
  localparam int W32 = DATA_W / 2;
  localparam int W16 = DATA_W / 4;
  localparam int W8  = DATA_W / 8;

  always_comb begin
    unique case (mode)
      WM_FULL:  y = d;
      WM_DUP32: y = {d[W32-1:0], d[W32-1:0]};
      WM_ZX32:  y = {{(DATA_W-W32){1'b0}}, d[W32-1:0]};
      WM_SX32:  y = {{(DATA_W-W32){d[W32-1]}}, d[W32-1:0]};
      WM_ZX16:  y = {{(DATA_W-W16){1'b0}}, d[W16-1:0]};
      WM_SX16:  y = {{(DATA_W-W16){d[W16-1]}}, d[W16-1:0]};
      WM_ZX8:   y = {{(DATA_W-W8){1'b0}}, d[W8-1:0]};
      WM_SX8:   y = {{(DATA_W-W8){d[W8-1]}}, d[W8-1:0]};
      default:  y = d;
    endcase
  end
endmodule

// File: rtl/int_mop_unit.sv
module int_mop_unit
  import int_mop_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int IMM_LOW_W = 25,
  parameter int CHUNK_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_kind,
  input  logic [DATA_W-1:0]    in_src0,
  input  logic [DATA_W-1:0]    in_src1,
  input  logic                 in_src1_cf,
  input  logic [DATA_W-1:0]    in_src2,
  input  logic                 in_three_src,
  input  logic [IMM_LOW_W-1:0] in_imm_low,
  input  logic                 in_imm_sign,
  input  logic [DATA_W-1:0]    in_pc,
  input  logic                 in_inv_src0,
  input  logic                 in_carry_sel,
  input  logic                 in_inv_cin,
  input  logic                 in_add_pc,
  input  logic [3:0]           in_lut,
  input  logic [2:0]           in_mode,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_result,
  output logic                 out_carry
);
  localparam int W16 = DATA_W / 4;
  localparam int W8  = DATA_W / 8;
  localparam int W32 = DATA_W / 2;

  logic [DATA_W-1:0] add_sum, logic_y, pre, shaped;
  logic              add_carry;
  logic              accept;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;

  int_mop_adder #(.DATA_W(DATA_W), .IMM_LOW_W(IMM_LOW_W), .CHUNK_W(CHUNK_W)) u_add (
    .src0(in_src0), .src1(in_src1), .src1_cf(in_src1_cf), .src2(in_src2),
    .three_src(in_three_src), .imm_low(in_imm_low), .imm_sign(in_imm_sign),
    .pc(in_pc), .inv_src0(in_inv_src0), .carry_sel(in_carry_sel),
    .inv_cin(in_inv_cin), .add_pc(in_add_pc), .sum(add_sum), .carry(add_carry)
  );

  int_mop_lut_logic #(.DATA_W(DATA_W)) u_logic (
    .a(in_src0), .b(in_src1), .lut(in_lut), .y(logic_y)
  );

  assign pre = in_kind ? logic_y : add_sum;

  int_mop_width_stage #(.DATA_W(DATA_W)) u_width (
    .d(pre), .mode(width_mode_e'(in_mode)), .y(shaped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_result <= shaped;
        out_carry  <= in_kind ? 1'b0 : add_carry;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_carry && out_result == '0));

  assert_valid_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid);

  assert_logic_no_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_kind)) |-> !out_carry);

  assert_zx8_upper_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == 3'd6) |-> out_result[DATA_W-1:W8] == '0);

  assert_sx16_upper_copy_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == 3'd5) |->
      out_result[DATA_W-1:W16] == {(DATA_W-W16){out_result[W16-1]}});

  assert_dup_halves_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode) == 3'd1) |->
      out_result[DATA_W-1:W32] == out_result[W32-1:0]);
endmodule

// File: tb/tb_int_mop_unit.sv
`timescale 1ns/1ps
module tb_int_mop_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_kind = 1'b0;
  logic [63:0] in_src0 = '0, in_src1 = '0, in_src2 = '0, in_pc = '0;
  logic        in_src1_cf = 1'b0, in_three_src = 1'b0;
  logic [24:0] in_imm_low = '0;
  logic        in_imm_sign = 1'b0;
  logic        in_inv_src0 = 1'b0, in_carry_sel = 1'b0, in_inv_cin = 1'b0, in_add_pc = 1'b0;
  logic [3:0]  in_lut = '0;
  logic [2:0]  in_mode = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_carry;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  int_mop_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_src0(in_src0), .in_src1(in_src1), .in_src1_cf(in_src1_cf), .in_src2(in_src2),
    .in_three_src(in_three_src), .in_imm_low(in_imm_low), .in_imm_sign(in_imm_sign),
    .in_pc(in_pc), .in_inv_src0(in_inv_src0), .in_carry_sel(in_carry_sel),
    .in_inv_cin(in_inv_cin), .in_add_pc(in_add_pc), .in_lut(in_lut), .in_mode(in_mode),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry)
  );

  function automatic logic [63:0] shape(input logic [63:0] v, input logic [2:0] m);
    case (m)
      3'd0: return v;
      3'd1: return {v[31:0], v[31:0]};
      3'd2: return {32'h0, v[31:0]};
      3'd3: return {{32{v[31]}}, v[31:0]};
      3'd4: return {48'h0, v[15:0]};
      3'd5: return {{48{v[15]}}, v[15:0]};
      3'd6: return {56'h0, v[7:0]};
      default: return {{56{v[7]}}, v[7:0]};
    endcase
  endfunction

  // reference: returns {carry, result} for the currently driven inputs
  function automatic logic [64:0] model();
    logic [63:0] a, b, c, p, imm, rest, r;
    logic [127:0] wide;
    longint signed simm;
    logic ci;
    if (in_kind) begin
      for (int i = 0; i < 64; i++) r[i] = in_lut[2*in_src0[i] + in_src1[i]];
      return {1'b0, shape(r, in_mode)};
    end
    a = in_inv_src0 ? ~in_src0 : in_src0;
    b = in_carry_sel ? 64'd0 : in_src1;
    ci = (in_carry_sel ? in_src1_cf : 1'b0) ? !in_inv_cin : in_inv_cin;
    p = in_add_pc ? in_pc : 64'd0;
    if (in_three_src) begin
      c = in_src2;
      simm = longint'(in_imm_low) - (in_imm_sign ? (longint'(1) <<< 25) : 0);
    end else begin
      c = 64'd0;
      simm = longint'(in_imm_low) + (longint'(in_src2[7:0]) <<< 25)
             - (in_imm_sign ? (longint'(1) <<< 33) : 0);
    end
    imm = 64'(simm);
    rest = b + c + imm + p;
    wide = 128'(a) + 128'(rest) + 128'(ci);
    return {wide[64], shape(wide[63:0], in_mode)};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive current inputs through one edge; compare every output at the next falling edge
  task automatic tick(input string tag);
    logic [64:0] e;
    logic ev;
    e  = model();
    ev = in_valid;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "valid", {63'd0, out_valid}, {63'd0, ev});
    if (ev) begin
      chk(tag, "result", out_result, e[63:0]);
      chk(tag, "carry", {63'd0, out_carry}, {63'd0, e[64]});
    end
  endtask

  task automatic clear_ctl();
    in_kind = 0; in_three_src = 0; in_inv_src0 = 0; in_carry_sel = 0; in_inv_cin = 0;
    in_add_pc = 0; in_mode = 0; in_imm_low = 0; in_imm_sign = 0; in_src1_cf = 0;
    in_src0 = 0; in_src1 = 0; in_src2 = 0; in_pc = 0; in_lut = 0;
  endtask

  initial begin
    fork
      begin
        #4000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid", {63'd0, out_valid}, 64'd0);
    chk("R1", "result", out_result, 64'd0);
    chk("R1", "ready_in_reset", {63'd0, in_ready}, 64'd0);
    rst = 0;
    #1;
    chk("R1", "ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    chk("R1", "valid_after", {63'd0, out_valid}, 64'd0);

    // R3 three-source add: 5+7+9+3 = 24
    in_valid = 1; in_three_src = 1;
    in_src0 = 5; in_src1 = 7; in_src2 = 9; in_imm_low = 3;
    tick("R3");
    chk("R3", "sum24", out_result, 64'd24);
    // R3 negative 26-bit immediate: -1
    clear_ctl(); in_three_src = 1; in_imm_sign = 1; in_imm_low = '1;
    tick("R3");
    chk("R3", "minus1", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
    // R4 two-source form: chunk 0x80 shifted to bit 25 = 2^32; upper src2 bits not added
    clear_ctl(); in_src0 = 1; in_src2 = 64'hFFFF_0000_0000_0080;
    tick("R4");
    chk("R4", "chunk_imm", out_result, 64'h1_0000_0001);
    // R4 negative 34-bit immediate
    clear_ctl(); in_imm_sign = 1; in_src2 = 64'hFF; in_imm_low = '1; in_src0 = 10;
    tick("R4");
    chk("R4", "neg34", out_result, 64'd9);
    // R6 subtract src1 - src0: 10 - 3 = 7 with carry (no borrow)
    clear_ctl(); in_inv_src0 = 1; in_inv_cin = 1; in_src0 = 3; in_src1 = 10;
    tick("R6");
    chk("R6", "sub", out_result, 64'd7);
    chk("R7", "noborrow", {63'd0, out_carry}, 64'd1);
    // R5 carry select with flag 1: src1 value ignored
    clear_ctl(); in_carry_sel = 1; in_src1_cf = 1; in_src1 = 64'h1234_5678_0000_0000; in_src0 = 10;
    tick("R5");
    chk("R5", "flag_cin", out_result, 64'd11);
    // R6 invert selected carry: flag 1 inverted -> 0
    in_inv_cin = 1;
    tick("R6");
    chk("R6", "inv_flag", out_result, 64'd10);
    // R5 carry select with flag 0
    in_inv_cin = 0; in_src1_cf = 0;
    tick("R5");
    chk("R5", "flag0", out_result, 64'd10);
    // R10 add program counter
    clear_ctl(); in_add_pc = 1; in_pc = 64'h1000; in_src0 = 4;
    tick("R10");
    chk("R10", "pc", out_result, 64'h1004);
    in_add_pc = 0;
    tick("R10");
    chk("R10", "no_pc", out_result, 64'd4);
    // R7 carry taken before width stage
    clear_ctl(); in_src0 = '1; in_src1 = 64'h181; in_mode = 3'd6;
    tick("R7");
    chk("R7", "zx8", out_result, 64'h80);
    chk("R7", "carry", {63'd0, out_carry}, 64'd1);
    // R8 logic ops, src2/imm/pc/controls ignored
    clear_ctl(); in_kind = 1; in_src0 = 64'hF0F0_F0F0_FFFF_0000; in_src1 = 64'hFF00_FF00_00FF_00FF;
    in_src2 = '1; in_imm_low = '1; in_pc = '1; in_add_pc = 1; in_inv_src0 = 1; in_inv_cin = 1;
    in_lut = 4'b0110;
    tick("R8");
    chk("R8", "xor", out_result, 64'h0FF0_0FF0_FF00_00FF);
    chk("R8", "nocarry", {63'd0, out_carry}, 64'd0);
    in_lut = 4'b1000;
    tick("R8");
    chk("R8", "and", out_result, 64'hF000_F000_00FF_0000);
    in_lut = 4'b1110;
    tick("R8");
    chk("R8", "or", out_result, 64'hFFF0_FFF0_FFFF_00FF);
    // R9 all width modes on a pass-through of src0 (lut selects a)
    clear_ctl(); in_kind = 1; in_lut = 4'b1100; in_src0 = 64'h89AB_CDEF_F1E2_8384;
    for (int m = 0; m < 8; m++) begin
      in_mode = 3'(m);
      tick("R9");
    end
    in_mode = 3'd1; tick("R9");
    chk("R9", "dup", out_result, 64'hF1E2_8384_F1E2_8384);
    in_mode = 3'd5; tick("R9");
    chk("R9", "sx16", out_result, 64'hFFFF_FFFF_FFFF_8384);
    in_mode = 3'd2; tick("R9");
    chk("R9", "zx32", out_result, 64'h0000_0000_F1E2_8384);
    // R2 idle cycles give no valid
    in_valid = 0;
    tick("R2");
    tick("R2");
    in_valid = 1; clear_ctl(); in_src0 = 2; in_src1 = 2;
    tick("R2");
    in_valid = 0;
    tick("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule